// File: doc/BRIEF.md
# Accelerator command and status controller

This block is the host-facing control core of a coprocessor. The host writes 8-bit command codes to it. The block decodes each code into one of three operations: run the program from address zero, wipe the data memory, or wipe the instruction memory. It starts the matching engine with a one-cycle start pulse and shows the operational state on an 8-bit status output. The engines themselves sit outside this block. Each one reports back with a one-cycle completion pulse.

The block also holds the error state of the coprocessor. An error register collects software faults reported by the execution engine and fatal faults from any source. A separate cause register records the fatal faults and freezes once the block has locked. A control bit decides whether software faults end the run as recoverable or as fatal. When an operation finishes, the block pulses a done interrupt. A recoverable stop also pulses the recoverable alert. Any fatal fault sends the block into a terminal locked state, and the fatal alert then stays high until the synchronous reset.

Top module: `acc_ctl`

## Requirements
- R1: After reset the outputs read as follows: status 0x00, error register 0, cause register 0, control bit 0, and every start, done and alert output 0.
- R2: A command write while idle moves status to 0x01 in the next cycle for code 0xD8, to 0x02 for code 0xC3 and to 0x03 for code 0x1E. In that same cycle exactly one pulse appears on the matching start output (execute, data wipe or instruction wipe).
- R3: A command write while the status is not 0x00 has no effect, and neither does a command whose code is none of the three above. In both cases status and the start outputs stay unchanged.
- R4: A busy operation returns status to 0x00 in the cycle after its own engine raises completion. The done output is high for exactly that one cycle. Completion pulses from the other two engines are ignored.
- R5: A nonzero software error vector during execution, with the control bit at 0, sets error bits 0 to 5 from that vector in the next cycle. In that same cycle status returns to 0x00, and done and the recoverable alert are each high for one cycle.
- R6: The control bit takes a write only while the status is 0x00. With the bit set, a software error during execution moves status to 0xFF and sets error bit 23 and cause bit 7 as well as the software bits.
- R7: Hardware fatal input bit i (for i from 0 to 5) sets error bit 16+i and cause bit i and moves status to 0xFF, all in the next cycle. From then on the fatal alert stays high.
- R8: A high escalation input is a fatal fault in the same cycle. It sets error bit 22 and cause bit 6 and moves status to 0xFF.
- R9: Once the status is 0xFF, only reset changes it. Commands, completions, clear writes, control writes and further fatal inputs leave status, the error register, the cause register and the control bit unchanged.
- R10: A clear write while the status is 0x00 zeroes the error register in the next cycle. A clear write during an operation or while locked is ignored.
- R11: Software error inputs are ignored unless the status is 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 8 | Command code |
| ctrl_we_i | input | 1 | Control bit write strobe |
| ctrl_i | input | 1 | Control bit write value (1 = software errors are fatal) |
| err_clr_i | input | 1 | Error register clear strobe |
| sw_err_i | input | 6 | Software error pulses from the execution engine |
| hw_fatal_i | input | 6 | Hardware fatal error pulses |
| esc_i | input | 1 | Escalation request |
| exec_done_i | input | 1 | Execution engine completion pulse |
| wipe_d_done_i | input | 1 | Data wipe engine completion pulse |
| wipe_i_done_i | input | 1 | Instruction wipe engine completion pulse |
| exec_start_o | output | 1 | Execution start pulse |
| wipe_d_start_o | output | 1 | Data wipe start pulse |
| wipe_i_start_o | output | 1 | Instruction wipe start pulse |
| status_o | output | 8 | Operational status code |
| ctrl_o | output | 1 | Current control bit |
| err_o | output | 32 | Error register |
| fatal_cause_o | output | 8 | Fatal cause register |
| done_o | output | 1 | Done interrupt pulse |
| alert_fatal_o | output | 1 | Fatal alert, held while locked |
| alert_recov_o | output | 1 | Recoverable alert pulse |

## Verification
The assertions check these properties on every cycle:
- any fatal input from an unlocked state reaches status 0xFF one cycle later;
- the locked status and the cause register never move while locked;
- a start pulse appears only after an idle cycle, and only together with its own busy code;
- done is a single-cycle pulse;
- the recoverable alert coincides with done and the return to idle.

Some behaviours need whole scenarios, and only the bench shows them:
- the decoding of every one of the 256 command codes;
- which engine's completion ends which operation;
- the exact bit positions in the error and cause registers;
- that clear and control writes are dropped outside idle.

// File: rtl/acc_ctl_pkg.sv
package acc_ctl_pkg;

  localparam int STAT_W = 8;

  typedef enum logic [STAT_W-1:0] {
    ST_IDLE   = 8'h00,
    ST_EXEC   = 8'h01,
    ST_WIPE_D = 8'h02,
    ST_WIPE_I = 8'h03,
    ST_LOCK   = 8'hFF
  } acc_state_e;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_EXEC,
    OP_WIPE_D,
    OP_WIPE_I
  } acc_op_e;

endpackage

// File: rtl/acc_ctl_decode.sv
module acc_ctl_decode
  import acc_ctl_pkg::*;
#(
  parameter int              CMD_W       = 8,
  parameter logic [CMD_W-1:0] CODE_EXEC   = 8'hD8,
  parameter logic [CMD_W-1:0] CODE_WIPE_D = 8'hC3,
  parameter logic [CMD_W-1:0] CODE_WIPE_I = 8'h1E
) (
  input  logic [CMD_W-1:0] code,
  output acc_op_e          op
);

  always_comb begin
    if (code == CODE_EXEC)        op = OP_EXEC;
    else if (code == CODE_WIPE_D) op = OP_WIPE_D;
    else if (code == CODE_WIPE_I) op = OP_WIPE_I;
    else                          op = OP_NONE;
  end

endmodule

// File: rtl/acc_ctl_fsm.sv
module acc_ctl_fsm
  import acc_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_we,
  input  acc_op_e    op,
  input  logic       fatal_evt,
  input  logic       sw_stop,
  input  logic       exec_done,
  input  logic       wipe_d_done,
  input  logic       wipe_i_done,
  output acc_state_e state_q,
  output logic [2:0] start_q,
  output logic       done_q,
  output logic       recov_q,
  output logic       locked_q
);

  acc_state_e state_d;
  logic [2:0] start_d;
  logic       done_d;
  logic       recov_d;

  always_comb begin
    state_d = state_q;
    start_d = 3'b000;
    done_d  = 1'b0;
    recov_d = 1'b0;
    if (state_q == ST_LOCK) begin
      state_d = ST_LOCK;
    end else if (fatal_evt) begin
      state_d = ST_LOCK;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_we) begin
            unique case (op)
              OP_EXEC:   begin state_d = ST_EXEC;   start_d = 3'b100; end
              OP_WIPE_D: begin state_d = ST_WIPE_D; start_d = 3'b010; end
              OP_WIPE_I: begin state_d = ST_WIPE_I; start_d = 3'b001; end
              default:   state_d = ST_IDLE;
            endcase
          end
        end
        ST_EXEC: begin
          if (sw_stop) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            recov_d = 1'b1;
          end else if (exec_done) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
        ST_WIPE_D: begin
          if (wipe_d_done) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
        ST_WIPE_I: begin
          if (wipe_i_done) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
        default: state_d = ST_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      start_q  <= 3'b000;
      done_q   <= 1'b0;
      recov_q  <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      start_q  <= start_d;
      done_q   <= done_d;
      recov_q  <= recov_d;
      locked_q <= (state_d == ST_LOCK);
    end
  end

endmodule

// File: rtl/acc_ctl_errs.sv
module acc_ctl_errs #(
  parameter int N_SW       = 6,
  parameter int N_HW_FATAL = 6,
  parameter int ERR_W      = 32,
  parameter int FATAL_LSB  = 16,
  localparam int N_FATAL   = N_HW_FATAL + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  idle,
  input  logic                  busy_exec,
  input  logic                  locked,
  input  logic                  ctrl_we,
  input  logic                  ctrl_d,
  input  logic                  clr_we,
  input  logic [N_SW-1:0]       sw_err,
  input  logic [N_HW_FATAL-1:0] hw_fatal,
  input  logic                  esc,
  output logic                  ctrl_q,
  output logic [ERR_W-1:0]      err_q,
  output logic [N_FATAL-1:0]    cause_q,
  output logic                  fatal_evt,
  output logic                  sw_stop
);

  logic [N_SW-1:0]    sw_new;
  logic               sw_hit;
  logic [N_FATAL-1:0] fatal_new;
  logic               clr;
  logic [ERR_W-1:0]   err_d;

  assign sw_new    = busy_exec ? sw_err : '0;
  assign sw_hit    = |sw_new;
  assign sw_stop   = sw_hit & ~ctrl_q;
  assign fatal_new = locked ? '0 : {sw_hit & ctrl_q, esc, hw_fatal};
  assign fatal_evt = |fatal_new;
  assign clr       = clr_we & idle;

  for (genvar b = 0; b < ERR_W; b++) begin : g_err
    if (b < N_SW) begin : g_sw
      assign err_d[b] = (clr ? 1'b0 : err_q[b]) | sw_new[b];
    end else if (b >= FATAL_LSB && b < FATAL_LSB + N_FATAL) begin : g_fatal
      assign err_d[b] = (clr ? 1'b0 : err_q[b]) | fatal_new[b-FATAL_LSB];
    end else begin : g_unused
      assign err_d[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q   <= '0;
      cause_q <= '0;
      ctrl_q  <= 1'b0;
    end else if (!locked) begin
      err_q   <= err_d;
      cause_q <= cause_q | fatal_new;
      if (ctrl_we && idle) ctrl_q <= ctrl_d;
    end
  end

endmodule

// File: rtl/acc_ctl.sv
module acc_ctl
  import acc_ctl_pkg::*;
#(
  parameter int               CMD_W       = 8,
  parameter int               N_SW        = 6,
  parameter int               N_HW_FATAL  = 6,
  parameter int               ERR_W       = 32,
  parameter int               FATAL_LSB   = 16,
  parameter logic [CMD_W-1:0] CODE_EXEC   = 8'hD8,
  parameter logic [CMD_W-1:0] CODE_WIPE_D = 8'hC3,
  parameter logic [CMD_W-1:0] CODE_WIPE_I = 8'h1E,
  localparam int              N_FATAL     = N_HW_FATAL + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_we_i,
  input  logic [CMD_W-1:0]      cmd_i,
  input  logic                  ctrl_we_i,
  input  logic                  ctrl_i,
  input  logic                  err_clr_i,
  input  logic [N_SW-1:0]       sw_err_i,
  input  logic [N_HW_FATAL-1:0] hw_fatal_i,
  input  logic                  esc_i,
  input  logic                  exec_done_i,
  input  logic                  wipe_d_done_i,
  input  logic                  wipe_i_done_i,
  output logic                  exec_start_o,
  output logic                  wipe_d_start_o,
  output logic                  wipe_i_start_o,
  output logic [STAT_W-1:0]     status_o,
  output logic                  ctrl_o,
  output logic [ERR_W-1:0]      err_o,
  output logic [N_FATAL-1:0]    fatal_cause_o,
  output logic                  done_o,
  output logic                  alert_fatal_o,
  output logic                  alert_recov_o
);

  acc_op_e    op;
  acc_state_e state_q;
  logic [2:0] start_q;
  logic       fatal_evt, sw_stop, locked_q;

  acc_ctl_decode #(
    .CMD_W(CMD_W), .CODE_EXEC(CODE_EXEC),
    .CODE_WIPE_D(CODE_WIPE_D), .CODE_WIPE_I(CODE_WIPE_I)
  ) u_dec (
    .code(cmd_i),
    .op  (op)
  );

  acc_ctl_errs #(
    .N_SW(N_SW), .N_HW_FATAL(N_HW_FATAL), .ERR_W(ERR_W), .FATAL_LSB(FATAL_LSB)
  ) u_errs (
    .clk      (clk),
    .rst      (rst),
    .idle     (state_q == ST_IDLE),
    .busy_exec(state_q == ST_EXEC),
    .locked   (locked_q),
    .ctrl_we  (ctrl_we_i),
    .ctrl_d   (ctrl_i),
    .clr_we   (err_clr_i),
    .sw_err   (sw_err_i),
    .hw_fatal (hw_fatal_i),
    .esc      (esc_i),
    .ctrl_q   (ctrl_o),
    .err_q    (err_o),
    .cause_q  (fatal_cause_o),
    .fatal_evt(fatal_evt),
    .sw_stop  (sw_stop)
  );

  acc_ctl_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .cmd_we     (cmd_we_i),
    .op         (op),
    .fatal_evt  (fatal_evt),
    .sw_stop    (sw_stop),
    .exec_done  (exec_done_i),
    .wipe_d_done(wipe_d_done_i),
    .wipe_i_done(wipe_i_done_i),
    .state_q    (state_q),
    .start_q    (start_q),
    .done_q     (done_o),
    .recov_q    (alert_recov_o),
    .locked_q   (locked_q)
  );

  assign status_o       = state_q;
  assign exec_start_o   = start_q[2];
  assign wipe_d_start_o = start_q[1];
  assign wipe_i_start_o = start_q[0];
  assign alert_fatal_o  = locked_q;

endmodule

// File: rtl/acc_ctl_chk.sv
module acc_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] hw_fatal_i,
  input logic       esc_i,
  input logic       exec_start_o,
  input logic       wipe_d_start_o,
  input logic       wipe_i_start_o,
  input logic [7:0] status_o,
  input logic [7:0] fatal_cause_o,
  input logic       done_o,
  input logic       alert_fatal_o,
  input logic       alert_recov_o
);

  a_r7_fatal_locks: assert property (@(posedge clk) disable iff (rst)
    ((|hw_fatal_i || esc_i) && status_o != 8'hFF) |=> status_o == 8'hFF);

  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    status_o == 8'hFF |=> (status_o == 8'hFF && $stable(fatal_cause_o)));

  a_r7_alert_has_cause: assert property (@(posedge clk) disable iff (rst)
    alert_fatal_o |-> fatal_cause_o != 8'h00);

  a_r2_start_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({exec_start_o, wipe_d_start_o, wipe_i_start_o}));

  a_r2_start_from_idle: assert property (@(posedge clk) disable iff (rst)
    (exec_start_o || wipe_d_start_o || wipe_i_start_o) |-> $past(status_o) == 8'h00);

  a_r2_exec_status: assert property (@(posedge clk) disable iff (rst)
    exec_start_o |-> status_o == 8'h01);

  a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r5_recov_with_done: assert property (@(posedge clk) disable iff (rst)
    alert_recov_o |-> (done_o && status_o == 8'h00));

endmodule

bind acc_ctl acc_ctl_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .hw_fatal_i    (hw_fatal_i),
  .esc_i         (esc_i),
  .exec_start_o  (exec_start_o),
  .wipe_d_start_o(wipe_d_start_o),
  .wipe_i_start_o(wipe_i_start_o),
  .status_o      (status_o),
  .fatal_cause_o (fatal_cause_o),
  .done_o        (done_o),
  .alert_fatal_o (alert_fatal_o),
  .alert_recov_o (alert_recov_o)
);

// File: tb/acc_ctl_test.sv
`timescale 1ns/1ps
module acc_ctl_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_we = 0, ctrl_we = 0, ctrl_d = 0, clr = 0, esc = 0;
  logic [7:0] cmd = 0;
  logic [5:0] sw_err = 0, hw_fatal = 0;
  logic ex_done = 0, wd_done = 0, wi_done = 0;
  logic ex_st, wd_st, wi_st, ctrl_q, done, a_fatal, a_recov;
  logic [7:0]  status, cause;
  logic [31:0] err;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  acc_ctl uut (
    .clk(clk), .rst(rst), .cmd_we_i(cmd_we), .cmd_i(cmd),
    .ctrl_we_i(ctrl_we), .ctrl_i(ctrl_d), .err_clr_i(clr),
    .sw_err_i(sw_err), .hw_fatal_i(hw_fatal), .esc_i(esc),
    .exec_done_i(ex_done), .wipe_d_done_i(wd_done), .wipe_i_done_i(wi_done),
    .exec_start_o(ex_st), .wipe_d_start_o(wd_st), .wipe_i_start_o(wi_st),
    .status_o(status), .ctrl_o(ctrl_q), .err_o(err), .fatal_cause_o(cause),
    .done_o(done), .alert_fatal_o(a_fatal), .alert_recov_o(a_recov)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    cmd_we = 0; ctrl_we = 0; clr = 0; esc = 0; sw_err = 0; hw_fatal = 0;
    ex_done = 0; wd_done = 0; wi_done = 0;
  endtask

  task automatic do_reset();
    quiet();
    rst = 1; tick(); tick(); rst = 0;
  endtask

  task automatic issue(input logic [7:0] c);
    cmd_we = 1; cmd = c; tick(); cmd_we = 0;
  endtask

  function automatic logic [7:0] exp_stat(input logic [7:0] c);
    if (c == 8'hD8) return 8'h01;
    if (c == 8'hC3) return 8'h02;
    if (c == 8'h1E) return 8'h03;
    return 8'h00;
  endfunction

  function automatic logic [2:0] exp_start(input logic [7:0] s);
    return (s == 8'h01) ? 3'b100 : (s == 8'h02) ? 3'b010 : (s == 8'h03) ? 3'b001 : 3'b000;
  endfunction

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] e;
    do_reset();
    chk("R1 status", status, 0);
    chk("R1 err", err, 0);
    chk("R1 cause", cause, 0);
    chk("R1 outputs", {ctrl_q, done, a_fatal, a_recov, ex_st, wd_st, wi_st}, 0);

    // R2/R3/R4: every code from idle
    for (int c = 0; c < 256; c++) begin
      issue(c[7:0]);
      e = exp_stat(c[7:0]);
      chk("R2/R3 status after cmd", status, e);
      chk("R2/R3 start pulses", {ex_st, wd_st, wi_st}, exp_start(e));
      if (e != 0) begin
        issue(8'h1E);
        chk("R3 busy cmd ignored", status, e);
        chk("R3 no start while busy", {ex_st, wd_st, wi_st}, 0);
        ex_done = (e != 8'h01); wd_done = (e != 8'h02); wi_done = (e != 8'h03);
        tick(); quiet();
        chk("R4 foreign completion ignored", status, e);
        chk("R4 no done on foreign", done, 0);
        ex_done = (e == 8'h01); wd_done = (e == 8'h02); wi_done = (e == 8'h03);
        tick(); quiet();
        chk("R4 idle after completion", status, 0);
        chk("R4 done high", done, 1);
        tick();
        chk("R4 done one cycle", done, 0);
      end
    end

    // R3: all codes while executing
    issue(8'hD8);
    for (int c = 0; c < 256; c++) begin
      issue(c[7:0]);
      chk("R3 exec busy ignores code", {status, ex_st, wd_st, wi_st}, {8'h01, 3'b000});
    end
    ex_done = 1; tick(); quiet();

    // R11: software errors while idle ignored
    sw_err = 6'h3F; tick(); quiet();
    chk("R11 idle sw err ignored", err, 0);
    chk("R11 no recov", a_recov, 0);
    issue(8'hC3);
    sw_err = 6'h3F; tick(); quiet();
    chk("R11 wipe sw err ignored", {status, err[7:0]}, {8'h02, 8'h00});
    wd_done = 1; tick(); quiet();

    // R5 / R10: recoverable software errors, one bit at a time
    for (int j = 0; j < 6; j++) begin
      issue(8'hD8);
      sw_err = 6'(1 << j); tick(); quiet();
      chk("R5 status idle", status, 0);
      chk("R5 done+recov", {done, a_recov}, 2'b11);
      chk("R5 err bit", err, 32'(1 << j));
      tick();
      chk("R5 pulses end", {done, a_recov}, 2'b00);
      clr = 1; tick(); quiet();
      chk("R10 clear idle", err, 0);
    end

    // R10 / R6: clear and control write ignored while busy
    issue(8'hD8);
    sw_err = 6'h01; tick(); quiet();
    issue(8'hD8);
    clr = 1; ctrl_we = 1; ctrl_d = 1; tick(); quiet();
    chk("R10 clear busy ignored", err, 32'h1);
    chk("R6 ctrl busy ignored", ctrl_q, 0);
    ex_done = 1; tick(); quiet();
    ctrl_we = 1; ctrl_d = 1; tick(); quiet();
    chk("R6 ctrl idle write", ctrl_q, 1);
    issue(8'hD8);
    sw_err = 6'h04; tick(); quiet();
    chk("R6 fatal sw status", status, 8'hFF);
    chk("R6 fatal sw err", err, 32'h0080_0005);
    chk("R6 fatal sw cause", cause, 8'h80);
    chk("R6 no done/recov", {done, a_recov, a_fatal}, 3'b001);

    // R7/R8/R9: each fatal source
    for (int i = 0; i < 7; i++) begin
      do_reset();
      if (i % 2 == 0) issue(8'hC3);
      if (i == 6) esc = 1; else hw_fatal = 6'(1 << i);
      tick(); quiet();
      chk(i == 6 ? "R8 status" : "R7 status", status, 8'hFF);
      chk(i == 6 ? "R8 err" : "R7 err", err, 32'(1 << (16 + i)));
      chk(i == 6 ? "R8 cause" : "R7 cause", cause, 32'(1 << i));
      chk("R7 alert", a_fatal, 1);
      cmd_we = 1; cmd = 8'hD8; clr = 1; ctrl_we = 1; ctrl_d = 1;
      ex_done = 1; wd_done = 1; hw_fatal = 6'(1 << ((i + 1) % 6)); esc = 1;
      tick(); quiet(); tick();
      chk("R9 locked status", status, 8'hFF);
      chk("R9 err frozen", err, 32'(1 << (16 + i)));
      chk("R9 cause frozen", cause, 32'(1 << i));
      chk("R9 ctrl frozen/no start", {ctrl_q, ex_st, done, a_fatal}, 4'b0001);
    end
    do_reset();
    chk("R9 reset exits lock", {status, 7'(0), a_fatal}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule